// File: doc/BRIEF.md
# Packed Float-Integer Lane Converter

The block converts every lane of a packed vector word at once, either from floating-point to integer or from integer to floating-point. A single lane holds either a 16-bit half-precision value or a 32-bit single-precision value, and the integer on the other side of the conversion always has the same width. There is no widening, no narrowing and no scaling by fractional bits. A size code selects the lane width. An op code selects the direction and whether the integer side is signed or unsigned.

Each 64-bit part goes through an identical part converter. A wide request converts both 64-bit parts with the same lane layout. A narrow request converts only the low part and leaves the upper part of the result as it was. The rounding follows from the direction alone: float-to-integer always truncates toward zero, and integer-to-float always rounds to nearest with ties to even. A rejected request raises an undefined-operation output for one cycle and changes neither the result nor the flags. Two sticky flags gather invalid-operation and inexact events until reset.

Top module: `fic_conv`

## Requirements
- R1: A request accepted on `valid_i` at a rising clock edge produces `valid_o`, `undef_o` and the updated `result_o` in the cycle after that edge (one register stage).
- R2: Size code 2'b01 selects four 16-bit half-precision lanes per 64-bit part, and size code 2'b10 selects two 32-bit single-precision lanes, with lane 0 in the least significant bits. Size codes 2'b00 and 2'b11 raise `undef_o` and leave `result_o` and both sticky flags unchanged.
- R3: Size code 2'b01 with `half_en_i` low raises `undef_o` and leaves the result unchanged.
- R4: A wide request (`wide_i`=1) converts both 64-bit parts. If either `src_odd_i` or `dst_odd_i` is high, the wide request raises `undef_o` instead.
- R5: A narrow request writes only `result_o[63:0]`. Bits 127:64 keep their previous value.
- R6: `op_i[1]`=1 selects float-to-integer and `op_i[1]`=0 selects integer-to-float. `op_i[0]`=1 makes the integer side unsigned, and `op_i[0]`=0 makes it two's complement signed.
- R7: Float-to-integer rounds toward zero. For example, 1.5 gives 1, -1.5 gives -1, and ±0.5 gives 0.
- R8: Float-to-integer saturates out-of-range values, infinities included, to the integer range limits and sets the invalid sticky flag. A NaN gives 0 and sets the invalid flag. A negative value of magnitude at least 1 converted to unsigned gives 0 and sets the invalid flag. A value that truncates to a representable integer, such as -2^31 to signed 32-bit or -0.5 to unsigned, sets no flag.
- R9: Subnormal floating-point inputs are flushed to zero and give integer 0 without raising a flag.
- R10: Integer-to-float rounds to nearest, ties to even, and sets the inexact sticky flag when any precision is lost. For example, 2^24+1 gives 0x4B800000, 2^24+3 gives 0x4B800002, and unsigned 16-bit 65535 overflows to half-precision infinity 0x7C00.
- R11: Only accepted requests set the sticky flags. Once set, a flag stays high until reset.
- R12: While `rst_ni` is low, `valid_o`, `undef_o`, `result_o` and both sticky flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| size_i | input | 2 | Lane size code |
| op_i | input | 2 | Bit 1 direction, bit 0 unsigned integer side |
| wide_i | input | 1 | Convert both 64-bit parts |
| half_en_i | input | 1 | Half-precision lanes permitted |
| src_odd_i | input | 1 | Low bit of the source register index |
| dst_odd_i | input | 1 | Low bit of the destination register index |
| src_i | input | 128 | Packed source operand |
| valid_o | output | 1 | Result cycle strobe |
| undef_o | output | 1 | Request rejected |
| result_o | output | 128 | Packed result |
| invalid_sticky_o | output | 1 | Sticky invalid-operation flag |
| inexact_sticky_o | output | 1 | Sticky inexact flag |

## Verification
The checker tests the control behaviour on every cycle:
- the one-cycle strobe timing;
- rejection of reserved size codes, of disabled half lanes and of odd indices on wide requests;
- holding of the result on idle and rejected cycles, and of the upper part on narrow requests;
- that the sticky flags never fall, and that they rise only on an accepted result.

The numeric behaviour can only be shown by the bench's directed scenarios. This covers truncation, saturation limits, NaN and subnormal handling, and ties-to-even rounding. The bench compares each lane against values worked out by hand from the format definitions.

// File: rtl/fic_pkg.sv
package fic_pkg;
  typedef enum logic [1:0] {
    SZ_RSV_LO = 2'b00,
    SZ_HALF   = 2'b01,
    SZ_SINGLE = 2'b10,
    SZ_RSV_HI = 2'b11
  } lane_size_e;

  // exponent field width for a lane width
  function automatic int lane_exp_w(input int ew);
    return (ew == 16) ? 5 : 8;
  endfunction
endpackage

// File: rtl/fic_f2i_lane.sv
module fic_f2i_lane
  import fic_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic [EW-1:0] a_i,
  input  logic          uns_i,
  output logic [EW-1:0] z_o,
  output logic          inv_o
);
  localparam int XW   = lane_exp_w(EW);
  localparam int MW   = EW - 1 - XW;
  localparam int BIAS = (1 << (XW - 1)) - 1;
  localparam int FW   = EW + MW + 1;

  logic          sgn;
  logic [XW-1:0] ex;
  logic [MW-1:0] mn;
  logic [XW-1:0] diff;
  logic [FW-1:0] full;
  logic [EW-1:0] mag;
  logic          is_nan, tiny, big;

  assign {sgn, ex, mn} = a_i;
  assign is_nan = (&ex) && (|mn);
  assign tiny   = ex < XW'(BIAS);        // |x| < 1, subnormals included
  assign big    = ex >= XW'(BIAS + EW);  // |x| >= 2^EW, infinity included
  assign diff   = ex - XW'(BIAS);
  assign full   = FW'({1'b1, mn}) << diff;
  assign mag    = EW'(full >> MW);

  always_comb begin
    inv_o = 1'b0;
    z_o   = '0;
    if (is_nan) begin
      inv_o = 1'b1;
    end else if (tiny) begin
      z_o = '0;
    end else if (uns_i) begin
      if (sgn) begin
        inv_o = 1'b1;
      end else if (big) begin
        inv_o = 1'b1;
        z_o   = '1;
      end else begin
        z_o = mag;
      end
    end else if (!sgn) begin
      if (big || mag[EW-1]) begin
        inv_o = 1'b1;
        z_o   = {1'b0, {(EW-1){1'b1}}};
      end else begin
        z_o = mag;
      end
    end else if (big || (mag[EW-1] && (|mag[EW-2:0]))) begin
      inv_o = 1'b1;
      z_o   = {1'b1, {(EW-1){1'b0}}};
    end else begin
      z_o = -mag;
    end
  end
endmodule

// File: rtl/fic_i2f_lane.sv
module fic_i2f_lane
  import fic_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic [EW-1:0] a_i,
  input  logic          uns_i,
  output logic [EW-1:0] z_o,
  output logic          inx_o
);
  localparam int XW   = lane_exp_w(EW);
  localparam int MW   = EW - 1 - XW;
  localparam int BIAS = (1 << (XW - 1)) - 1;
  localparam int SHW  = $clog2(EW);
  localparam int RW   = EW - 1 - MW;

  logic           neg, guard, stk, rnd;
  logic [EW-1:0]  mag;
  logic [SHW-1:0] pos;
  logic [EW-2:0]  norm;
  logic [MW-1:0]  mant;
  logic [RW-1:0]  rem;
  logic [XW-1:0]  exf;
  logic [EW-2:0]  body;

  assign neg = !uns_i && a_i[EW-1];
  assign mag = neg ? -a_i : a_i;

  always_comb begin
    pos = '0;
    for (int i = 0; i < EW; i++) begin
      if (mag[i]) pos = SHW'(i);
    end
  end

  // leading one shifted out of the top; remaining bits are fraction
  assign norm  = (EW-1)'(mag << (SHW'(EW - 1) - pos));
  assign mant  = norm[EW-2 -: MW];
  assign rem   = norm[RW-1:0];
  assign guard = rem[RW-1];
  assign stk   = |rem[RW-2:0];
  assign rnd   = guard && (stk || mant[0]);
  assign exf   = XW'(BIAS) + {{(XW-SHW){1'b0}}, pos};
  assign body  = {exf, mant} + {{(EW-2){1'b0}}, rnd};

  assign z_o   = (mag == '0) ? '0 : {neg, body};
  assign inx_o = |rem;
endmodule

// File: rtl/fic_word_cvt.sv
module fic_word_cvt
  import fic_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  lane_size_e        size_i,
  input  logic              to_int_i,
  input  logic              uns_i,
  output logic [DATA_W-1:0] z_o,
  output logic              inv_o,
  output logic              inx_o
);
  localparam int N16 = DATA_W / 16;
  localparam int N32 = DATA_W / 32;

  logic [DATA_W-1:0] h_f2i, h_i2f, s_f2i, s_i2f;
  logic [N16-1:0]    h_inv, h_inx;
  logic [N32-1:0]    s_inv, s_inx;

  for (genvar g = 0; g < N16; g++) begin : g_half
    fic_f2i_lane #(.EW(16)) u_f2i (
      .a_i(a_i[g*16 +: 16]), .uns_i(uns_i), .z_o(h_f2i[g*16 +: 16]), .inv_o(h_inv[g])
    );
    fic_i2f_lane #(.EW(16)) u_i2f (
      .a_i(a_i[g*16 +: 16]), .uns_i(uns_i), .z_o(h_i2f[g*16 +: 16]), .inx_o(h_inx[g])
    );
  end

  for (genvar g = 0; g < N32; g++) begin : g_single
    fic_f2i_lane #(.EW(32)) u_f2i (
      .a_i(a_i[g*32 +: 32]), .uns_i(uns_i), .z_o(s_f2i[g*32 +: 32]), .inv_o(s_inv[g])
    );
    fic_i2f_lane #(.EW(32)) u_i2f (
      .a_i(a_i[g*32 +: 32]), .uns_i(uns_i), .z_o(s_i2f[g*32 +: 32]), .inx_o(s_inx[g])
    );
  end

  always_comb begin
    z_o   = '0;
    inv_o = 1'b0;
    inx_o = 1'b0;
    unique case (size_i)
      SZ_HALF: begin
        z_o   = to_int_i ? h_f2i : h_i2f;
        inv_o = to_int_i && (|h_inv);
        inx_o = !to_int_i && (|h_inx);
      end
      SZ_SINGLE: begin
        z_o   = to_int_i ? s_f2i : s_i2f;
        inv_o = to_int_i && (|s_inv);
        inx_o = !to_int_i && (|s_inx);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fic_conv.sv
module fic_conv
  import fic_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_PART = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic [1:0]                   size_i,
  input  logic [1:0]                   op_i,
  input  logic                         wide_i,
  input  logic                         half_en_i,
  input  logic                         src_odd_i,
  input  logic                         dst_odd_i,
  input  logic [DATA_W*NUM_PART-1:0]   src_i,
  output logic                         valid_o,
  output logic                         undef_o,
  output logic [DATA_W*NUM_PART-1:0]   result_o,
  output logic                         invalid_sticky_o,
  output logic                         inexact_sticky_o
);
  localparam int TOT_W = DATA_W * NUM_PART;

  lane_size_e                      size;
  logic                            illegal, inv_any, inx_any;
  logic [NUM_PART-1:0]             active, part_inv, part_inx;
  logic [NUM_PART-1:0][DATA_W-1:0] part_z;
  logic [TOT_W-1:0]                res_q;

  assign size    = lane_size_e'(size_i);
  assign illegal = !((size == SZ_HALF) || (size == SZ_SINGLE))
                || ((size == SZ_HALF) && !half_en_i)
                || (wide_i && (src_odd_i || dst_odd_i));

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    fic_word_cvt #(.DATA_W(DATA_W)) u_word (
      .a_i     (src_i[p*DATA_W +: DATA_W]),
      .size_i  (size),
      .to_int_i(op_i[1]),
      .uns_i   (op_i[0]),
      .z_o     (part_z[p]),
      .inv_o   (part_inv[p]),
      .inx_o   (part_inx[p])
    );
    if (p == 0) begin : g_low
      assign active[p] = 1'b1;
    end else begin : g_up
      assign active[p] = wide_i;
    end
  end

  assign inv_any = |(part_inv & active);
  assign inx_any = |(part_inx & active);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o          <= 1'b0;
      undef_o          <= 1'b0;
      res_q            <= '0;
      invalid_sticky_o <= 1'b0;
      inexact_sticky_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      undef_o <= valid_i && illegal;
      if (valid_i && !illegal) begin
        for (int p = 0; p < NUM_PART; p++) begin
          if (active[p]) res_q[p*DATA_W +: DATA_W] <= part_z[p];
        end
        invalid_sticky_o <= invalid_sticky_o || inv_any;
        inexact_sticky_o <= inexact_sticky_o || inx_any;
      end
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/fic_conv_chk.sv
module fic_conv_chk #(
  parameter int DATA_W   = 64,
  parameter int NUM_PART = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       valid_i,
  input logic [1:0]                 size_i,
  input logic                       wide_i,
  input logic                       half_en_i,
  input logic                       src_odd_i,
  input logic                       dst_odd_i,
  input logic                       valid_o,
  input logic                       undef_o,
  input logic [DATA_W*NUM_PART-1:0] result_o,
  input logic                       invalid_sticky_o,
  input logic                       inexact_sticky_o
);
  localparam int TOT_W = DATA_W * NUM_PART;

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  // R1
  undef_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> valid_o);

  // R2
  rsv_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && (size_i == 2'b00 || size_i == 2'b11)) |-> undef_o);

  // R3
  half_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && size_i == 2'b01 && !half_en_i) |-> undef_o);

  // R4
  odd_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && wide_i && (src_odd_i || dst_odd_i)) |-> undef_o);

  // R2
  hold_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o || undef_o) |-> result_o == $past(result_o));

  // R5
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && !wide_i) |-> result_o[TOT_W-1:DATA_W] == $past(result_o[TOT_W-1:DATA_W]));

  // R11
  inv_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(invalid_sticky_o) |-> invalid_sticky_o);

  // R11
  inx_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inexact_sticky_o) |-> inexact_sticky_o);

  // R11
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(invalid_sticky_o) || $rose(inexact_sticky_o)) |-> (valid_o && !undef_o));
endmodule

bind fic_conv fic_conv_chk #(.DATA_W(DATA_W), .NUM_PART(NUM_PART)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .size_i(size_i), .wide_i(wide_i),
  .half_en_i(half_en_i), .src_odd_i(src_odd_i), .dst_odd_i(dst_odd_i), .valid_o(valid_o),
  .undef_o(undef_o), .result_o(result_o), .invalid_sticky_o(invalid_sticky_o),
  .inexact_sticky_o(inexact_sticky_o)
);

// File: tb/fic_conv_tb.sv
module fic_conv_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   size_i = 2'b00;
  logic [1:0]   op_i = 2'b00;
  logic         wide_i = 1'b0;
  logic         half_en_i = 1'b1;
  logic         src_odd_i = 1'b0;
  logic         dst_odd_i = 1'b0;
  logic [127:0] src_i = '0;
  logic         valid_o, undef_o, invalid_sticky_o, inexact_sticky_o;
  logic [127:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [127:0] exp_res = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fic_conv u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .size_i(size_i), .op_i(op_i),
    .wide_i(wide_i), .half_en_i(half_en_i), .src_odd_i(src_odd_i), .dst_odd_i(dst_odd_i),
    .src_i(src_i), .valid_o(valid_o), .undef_o(undef_o), .result_o(result_o),
    .invalid_sticky_o(invalid_sticky_o), .inexact_sticky_o(inexact_sticky_o)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one request; returns with outputs of that request settled
  task automatic run_op(input logic [1:0] sz, input logic [1:0] op, input logic w,
                        input logic he, input logic so, input logic dodd,
                        input logic [127:0] d, input logic exp_undef);
    @(negedge clk_i);
    size_i = sz; op_i = op; wide_i = w; half_en_i = he;
    src_odd_i = so; dst_odd_i = dodd; src_i = d; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R1 valid_o", {127'd0, valid_o}, 128'd1);
    chk("R2 undef_o", {127'd0, undef_o}, {127'd0, exp_undef});
  endtask

  task automatic t_reset;
    chk("R12 reset valid", {127'd0, valid_o}, 128'd0);
    chk("R12 reset undef", {127'd0, undef_o}, 128'd0);
    chk("R12 reset result", result_o, 128'd0);
    chk("R12 reset flags", {126'd0, invalid_sticky_o, inexact_sticky_o}, 128'd0);
  endtask

  task automatic t_trunc_single;
    // R7 R6 signed single: 1.5, -1.5 ; upper junk ignored in narrow mode (R5)
    run_op(2'b10, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1, {64'hDEAD_BEEF_0123_4567, 32'hBFC00000, 32'h3FC00000}, 1'b0);
    exp_res[63:0] = {32'hFFFFFFFF, 32'h00000001};
    chk("R7 trunc 1.5/-1.5", result_o, exp_res);
    run_op(2'b10, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, {64'd0, 32'hBF000000, 32'h3F000000}, 1'b0);
    exp_res[63:0] = 64'd0;
    chk("R7 trunc +-0.5", result_o, exp_res);
    // R8 exact minimum, no flag ; R9 subnormal flush
    run_op(2'b10, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, {64'd0, 32'h00000001, 32'hCF000000}, 1'b0);
    exp_res[63:0] = {32'h00000000, 32'h80000000};
    chk("R8 R9 min/subnormal", result_o, exp_res);
    // R6 unsigned: largest below 2^32, -0.5
    run_op(2'b10, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, {64'd0, 32'hBF000000, 32'h4F7FFFFF}, 1'b0);
    exp_res[63:0] = {32'h00000000, 32'hFFFFFF00};
    chk("R6 unsigned single", result_o, exp_res);
    chk("R11 no flags yet", {126'd0, invalid_sticky_o, inexact_sticky_o}, 128'd0);
  endtask

  task automatic t_half;
    // R2 four half lanes: 1.5, -1.5, 0.5, subnormal
    run_op(2'b01, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, {64'd0, 16'h0001, 16'h3800, 16'hBE00, 16'h3E00}, 1'b0);
    exp_res[63:0] = {16'h0000, 16'h0000, 16'hFFFF, 16'h0001};
    chk("R2 half f2i signed", result_o, exp_res);
    run_op(2'b01, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, {64'd0, 16'h4180, 16'h8000, 16'h6400, 16'h7BFF}, 1'b0);
    exp_res[63:0] = {16'h0002, 16'h0000, 16'h0400, 16'hFFE0};
    chk("R6 half f2i unsigned", result_o, exp_res);
    run_op(2'b01, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, {64'd0, 16'h8000, 16'h0000, 16'hFFFE, 16'h0001}, 1'b0);
    exp_res[63:0] = {16'hF800, 16'h0000, 16'hC000, 16'h3C00};
    chk("R10 half i2f exact", result_o, exp_res);
    chk("R11 still clear", {126'd0, invalid_sticky_o, inexact_sticky_o}, 128'd0);
  endtask

  task automatic t_wide;
    run_op(2'b10, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0,
           {32'd3, 32'd2, 32'hFFFFFFFF, 32'd1}, 1'b0);
    exp_res = {32'h40400000, 32'h40000000, 32'hBF800000, 32'h3F800000};
    chk("R4 wide both parts", result_o, exp_res);
    run_op(2'b10, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 128'd5, 1'b1);
    chk("R4 odd source held", result_o, exp_res);
    run_op(2'b10, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 128'd5, 1'b1);
    chk("R4 odd dest held", result_o, exp_res);
    // R5 narrow after wide keeps upper part
    run_op(2'b10, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, {64'd9, 32'd0, 32'd4}, 1'b0);
    exp_res[63:0] = {32'h00000000, 32'h40800000};
    chk("R5 upper kept", result_o, exp_res);
  endtask

  task automatic t_illegal;
    // R2 reserved sizes with NaN data: no change, no flag
    run_op(2'b00, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, {2{64'h7FC000007FC00000}}, 1'b1);
    chk("R2 size 00 held", result_o, exp_res);
    run_op(2'b11, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, {2{64'h7FC000007FC00000}}, 1'b1);
    chk("R2 size 11 held", result_o, exp_res);
    run_op(2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, {2{64'h7E007E007E007E00}}, 1'b1);
    chk("R3 half disabled held", result_o, exp_res);
    chk("R11 rejected sets no flag", {126'd0, invalid_sticky_o, inexact_sticky_o}, 128'd0);
  endtask

  task automatic t_round;
    run_op(2'b10, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, {64'd0, 32'h01000003, 32'h01000001}, 1'b0);
    exp_res[63:0] = {32'h4B800002, 32'h4B800000};
    chk("R10 ties to even single", result_o, exp_res);
    chk("R10 inexact set", {126'd0, invalid_sticky_o, inexact_sticky_o}, 128'd1);
    run_op(2'b01, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, {64'd0, 16'hFFFF, 16'h0803, 16'h0801, 16'h0001}, 1'b0);
    exp_res[63:0] = {16'h7C00, 16'h6802, 16'h6800, 16'h3C00};
    chk("R10 half rounding/overflow", result_o, exp_res);
  endtask

  task automatic t_sat;
    run_op(2'b10, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, {64'd0, 32'hFF800000, 32'h4F32D05E}, 1'b0);
    exp_res[63:0] = {32'h80000000, 32'h7FFFFFFF};
    chk("R8 saturate signed", result_o, exp_res);
    chk("R8 invalid set", {126'd0, invalid_sticky_o, inexact_sticky_o}, 128'd3);
    run_op(2'b10, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, {64'd0, 32'hBFC00000, 32'h7FC00000}, 1'b0);
    exp_res[63:0] = 64'd0;
    chk("R8 NaN and negative unsigned", result_o, exp_res);
    run_op(2'b01, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, {64'd0, 16'hFC00, 16'h7C00, 16'h7BFF, 16'hF800}, 1'b0);
    exp_res[63:0] = {16'h8000, 16'h7FFF, 16'h7FFF, 16'h8000};
    chk("R8 half saturate", result_o, exp_res);
  endtask

  task automatic t_rereset;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R11 flags cleared by reset", {126'd0, invalid_sticky_o, inexact_sticky_o}, 128'd0);
    chk("R12 result cleared", result_o, 128'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_trunc_single();
    t_half();
    t_wide();
    t_illegal();
    t_round();
    t_sat();
    t_rereset();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule